// File: doc/BRIEF.md
# Exception Vector and Entry Controller

This block sits beside the execute stage of a small processor. Each cycle in which an instruction is valid, it looks for exception causes: an odd-address word or long access or fetch, a bus error, an opcode in the reserved 1010 line, a TRAP with a 4-bit argument, a divide with a zero divisor, or a device interrupt. When several causes are present, it keeps the most urgent one and turns it into an 8-bit vector number.

Once an exception is taken, the controller owns the supervisor stack pointer and the status register. It writes a two-part frame through a stack-write port. The return PC goes in as a long word and the old SR as a word, so the SR ends up at the new top of stack with the PC two bytes above it. The controller then sets the supervisor bit and reads the handler address from the vector table at vector times four. That address is given to the fetch unit as a redirect.

A return request reverses the process. The controller reads the SR back from the top of stack and the PC from two bytes above it, releases the six bytes, and redirects fetch to the restored PC.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A valid instruction with `ex_div_zero` high and no higher cause selects vector 5.
- R2: A valid instruction with `ex_trap` high and argument n (0..15) and no higher cause selects vector 32+n.
- R3: An odd `ex_pc` is an address error, and so is a data access with `ex_mem_size` of 1 (word) or 2 (long) and `ex_mem_addr0` high. Either selects vector 3. A byte access (size 0) at an odd address raises no exception.
- R4: A valid instruction whose opcode upper nibble is 4'b1010 selects vector 10.
- R5: A bus error selects vector `BUS_ERR_VEC` (default 2). A device interrupt request selects the vector on `irq_vec`.
- R6: Priority from highest to lowest is: address error, bus error, reserved line, TRAP, divide by zero, device interrupt.
- R7: The stacked return PC is `ex_pc` for address error, bus error and reserved line. It is `ex_next_pc` for TRAP, divide by zero and device interrupt.
- R8: Entry writes the return PC as a long word at SP-4, then the old SR as a word at SP-6, and leaves SP reduced by 6.
- R9: After the SR write, the supervisor bit (bit 13) of `sr` is set. In the next cycle `vec_re` and `redirect_valid` are high, `vec_addr` is the vector times 4, and `redirect_pc` equals `vec_rdata`.
- R10: `busy` is high for exactly three cycles per entry. Causes presented while `busy` is high are ignored.
- R11: On `rte_req`, the controller reads the SR word at SP and then the PC long word at SP+2. The restored SR is visible after the first step, and `redirect_pc` gives the PC in the second step. SP then grows by 6 and `busy` lasts two cycles.
- R12: After reset, `ssp` is `SP_RESET`, `sr` is `SR_RESET` (supervisor set), `busy` is low, and no stack or vector access is made while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Instruction in execute stage is valid |
| ex_pc | input | AW | Address of the instruction in execute |
| ex_next_pc | input | AW | Address of the following instruction |
| ex_op_hi | input | 4 | Upper nibble of the opcode |
| ex_div_zero | input | 1 | Divide with zero divisor |
| ex_trap | input | 1 | TRAP instruction |
| ex_trap_num | input | 4 | TRAP argument |
| ex_mem_en | input | 1 | Data access in this instruction |
| ex_mem_size | input | 2 | 0 byte, 1 word, 2 long |
| ex_mem_addr0 | input | 1 | Least significant data address bit |
| ex_bus_err | input | 1 | Bus error reported for this instruction |
| irq_req | input | 1 | Device interrupt pending |
| irq_vec | input | 8 | Vector supplied by the device |
| rte_req | input | 1 | Return-from-exception request |
| sr_load | input | 1 | Write SR from execute (idle only, no start) |
| sr_load_val | input | 16 | Value for SR write |
| stk_rdata | input | AW | Stack read data, same cycle |
| vec_rdata | input | AW | Vector table read data, same cycle |
| busy | output | 1 | Entry or return sequence in progress |
| exc_vector | output | 8 | Vector of the last taken exception |
| sr | output | 16 | Status register |
| ssp | output | AW | Supervisor stack pointer |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_long | output | 1 | Stack access is long (else word) |
| stk_addr | output | AW | Stack access address |
| stk_wdata | output | AW | Stack write data |
| vec_re | output | 1 | Vector table read strobe |
| vec_addr | output | AW | Vector table address |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | AW | Redirect target |

## Verification
The checker assumes that stack and vector reads return data in the same cycle. It also assumes that `rte_req` arrives only while the controller is idle and that a return matches an earlier entry, so the stack pointer never wraps. The stimulus respects these assumptions. The bench models memory as a small byte array around the stack base and answers vector reads combinationally. Every return is issued only after its entry has completed, and nesting is kept shallow. Addresses and cause combinations are random, while the stack pointer stays within the modelled window.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int VEC_W = 8;

    localparam logic [VEC_W-1:0] VEC_ADDR_ERR  = 8'd3;
    localparam logic [VEC_W-1:0] VEC_DIV_ZERO  = 8'd5;
    localparam logic [VEC_W-1:0] VEC_LINE_1010 = 8'd10;
    localparam logic [VEC_W-1:0] VEC_TRAP_BASE = 8'd32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_FETCH,
        ST_POP_SR,
        ST_POP_PC
    } seq_state_e;

    typedef struct packed {
        logic             hit;
        logic [VEC_W-1:0] vec;
        logic             resume_next;
    } exc_pick_t;

    function automatic exc_pick_t pick_cause(
        input logic             addr_err,
        input logic             bus_err,
        input logic             line_1010,
        input logic             trap,
        input logic [3:0]       trap_num,
        input logic             div_zero,
        input logic             irq,
        input logic [VEC_W-1:0] irq_vec,
        input logic [VEC_W-1:0] bus_vec
    );
        exc_pick_t p;
        p = '{hit: 1'b1, vec: '0, resume_next: 1'b0};
        if (addr_err)       p.vec = VEC_ADDR_ERR;
        else if (bus_err)   p.vec = bus_vec;
        else if (line_1010) p.vec = VEC_LINE_1010;
        else if (trap) begin
            p.vec         = VEC_TRAP_BASE + {4'b0, trap_num};
            p.resume_next = 1'b1;
        end else if (div_zero) begin
            p.vec         = VEC_DIV_ZERO;
            p.resume_next = 1'b1;
        end else if (irq) begin
            p.vec         = irq_vec;
            p.resume_next = 1'b1;
        end else begin
            p.hit = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/exc_cause_detect.sv
module exc_cause_detect
    import exc_pkg::*;
#(
    parameter int               AW          = 32,
    parameter logic [VEC_W-1:0] BUS_ERR_VEC = 8'd2
) (
    input  logic             ex_valid,
    input  logic [AW-1:0]    ex_pc,
    input  logic [AW-1:0]    ex_next_pc,
    input  logic [3:0]       ex_op_hi,
    input  logic             ex_div_zero,
    input  logic             ex_trap,
    input  logic [3:0]       ex_trap_num,
    input  logic             ex_mem_en,
    input  logic [1:0]       ex_mem_size,
    input  logic             ex_mem_addr0,
    input  logic             ex_bus_err,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    output exc_pick_t        pick,
    output logic [AW-1:0]    ret_pc
);
    logic wide_access;
    logic addr_err;
    logic line_1010;

    always_comb begin
        wide_access = (acc_size_e'(ex_mem_size) == SZ_WORD) ||
                      (acc_size_e'(ex_mem_size) == SZ_LONG);
        addr_err    = ex_pc[0] || (ex_mem_en && wide_access && ex_mem_addr0);
        line_1010   = (ex_op_hi == 4'b1010);
        if (ex_valid)
            pick = pick_cause(addr_err, ex_bus_err, line_1010, ex_trap,
                              ex_trap_num, ex_div_zero, irq_req, irq_vec,
                              BUS_ERR_VEC);
        else
            pick = '{hit: 1'b0, vec: '0, resume_next: 1'b0};
        ret_pc = pick.resume_next ? ex_next_pc : ex_pc;
    end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_exc,
    input  logic       start_rte,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_exc)      nxt = ST_PUSH_PC;
                else if (start_rte) nxt = ST_POP_SR;
            end
            ST_PUSH_PC: nxt = ST_PUSH_SR;
            ST_PUSH_SR: nxt = ST_FETCH;
            ST_FETCH:   nxt = ST_IDLE;
            ST_POP_SR:  nxt = ST_POP_PC;
            ST_POP_PC:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/exc_frame_regs.sv
module exc_frame_regs
    import exc_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [31:0] SP_RESET = 32'h0000_0800,
    parameter logic [15:0] SR_RESET = 16'h2700,
    parameter int          S_BIT    = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_state_e       state,
    input  logic             start_exc,
    input  logic             start_rte,
    input  exc_pick_t        pick,
    input  logic [AW-1:0]    ret_pc_in,
    input  logic             sr_load,
    input  logic [15:0]      sr_load_val,
    input  logic [15:0]      pop_sr,
    output logic [AW-1:0]    ssp_q,
    output logic [15:0]      sr_q,
    output logic [VEC_W-1:0] vec_q,
    output logic [AW-1:0]    ret_q,
    output logic [15:0]      saved_sr_q
);
    localparam logic [AW-1:0] FRAME_BYTES = AW'(6);

    always_ff @(posedge clk) begin
        if (rst) begin
            ssp_q      <= AW'(SP_RESET);
            sr_q       <= SR_RESET;
            vec_q      <= '0;
            ret_q      <= '0;
            saved_sr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_exc) begin
                        vec_q      <= pick.vec;
                        ret_q      <= ret_pc_in;
                        saved_sr_q <= sr_q;
                    end else if (!start_rte && sr_load) begin
                        sr_q <= sr_load_val;
                    end
                end
                ST_PUSH_SR: begin
                    ssp_q       <= ssp_q - FRAME_BYTES;
                    sr_q[S_BIT] <= 1'b1;
                end
                ST_POP_SR: sr_q  <= pop_sr;
                ST_POP_PC: ssp_q <= ssp_q + FRAME_BYTES;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int          AW          = 32,
    parameter logic [31:0] SP_RESET    = 32'h0000_0800,
    parameter logic [15:0] SR_RESET    = 16'h2700,
    parameter int          S_BIT       = 13,
    parameter logic [7:0]  BUS_ERR_VEC = 8'd2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_pc,
    input  logic [AW-1:0] ex_next_pc,
    input  logic [3:0]    ex_op_hi,
    input  logic          ex_div_zero,
    input  logic          ex_trap,
    input  logic [3:0]    ex_trap_num,
    input  logic          ex_mem_en,
    input  logic [1:0]    ex_mem_size,
    input  logic          ex_mem_addr0,
    input  logic          ex_bus_err,
    input  logic          irq_req,
    input  logic [7:0]    irq_vec,
    input  logic          rte_req,
    input  logic          sr_load,
    input  logic [15:0]   sr_load_val,
    input  logic [AW-1:0] stk_rdata,
    input  logic [AW-1:0] vec_rdata,
    output logic          busy,
    output logic [7:0]    exc_vector,
    output logic [15:0]   sr,
    output logic [AW-1:0] ssp,
    output logic          stk_we,
    output logic          stk_re,
    output logic          stk_long,
    output logic [AW-1:0] stk_addr,
    output logic [AW-1:0] stk_wdata,
    output logic          vec_re,
    output logic [AW-1:0] vec_addr,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc
);
    localparam logic [AW-1:0] PC_OFS = AW'(4);
    localparam logic [AW-1:0] SR_OFS = AW'(6);
    localparam logic [AW-1:0] UP_OFS = AW'(2);

    exc_pick_t     pick;
    logic [AW-1:0] ret_pc;
    seq_state_e    state;
    logic          start_exc;
    logic          start_rte;
    logic [AW-1:0] ret_q;
    logic [15:0]   saved_sr_q;

    exc_cause_detect #(.AW(AW), .BUS_ERR_VEC(BUS_ERR_VEC)) u_detect (
        .ex_valid    (ex_valid),
        .ex_pc       (ex_pc),
        .ex_next_pc  (ex_next_pc),
        .ex_op_hi    (ex_op_hi),
        .ex_div_zero (ex_div_zero),
        .ex_trap     (ex_trap),
        .ex_trap_num (ex_trap_num),
        .ex_mem_en   (ex_mem_en),
        .ex_mem_size (ex_mem_size),
        .ex_mem_addr0(ex_mem_addr0),
        .ex_bus_err  (ex_bus_err),
        .irq_req     (irq_req),
        .irq_vec     (irq_vec),
        .pick        (pick),
        .ret_pc      (ret_pc)
    );

    assign busy      = (state != ST_IDLE);
    assign start_exc = !busy && pick.hit;
    assign start_rte = !busy && !pick.hit && rte_req;

    exc_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_exc(start_exc),
        .start_rte(start_rte),
        .state    (state)
    );

    exc_frame_regs #(
        .AW(AW), .SP_RESET(SP_RESET), .SR_RESET(SR_RESET), .S_BIT(S_BIT)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .start_exc  (start_exc),
        .start_rte  (start_rte),
        .pick       (pick),
        .ret_pc_in  (ret_pc),
        .sr_load    (sr_load),
        .sr_load_val(sr_load_val),
        .pop_sr     (stk_rdata[15:0]),
        .ssp_q      (ssp),
        .sr_q       (sr),
        .vec_q      (exc_vector),
        .ret_q      (ret_q),
        .saved_sr_q (saved_sr_q)
    );

    always_comb begin
        stk_we         = 1'b0;
        stk_re         = 1'b0;
        stk_long       = 1'b0;
        stk_addr       = '0;
        stk_wdata      = '0;
        vec_re         = 1'b0;
        vec_addr       = '0;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        unique case (state)
            ST_PUSH_PC: begin
                stk_we    = 1'b1;
                stk_long  = 1'b1;
                stk_addr  = ssp - PC_OFS;
                stk_wdata = ret_q;
            end
            ST_PUSH_SR: begin
                stk_we    = 1'b1;
                stk_addr  = ssp - SR_OFS;
                stk_wdata = AW'(saved_sr_q);
            end
            ST_FETCH: begin
                vec_re         = 1'b1;
                vec_addr       = AW'(exc_vector) << 2;
                redirect_valid = 1'b1;
                redirect_pc    = vec_rdata;
            end
            ST_POP_SR: begin
                stk_re   = 1'b1;
                stk_addr = ssp;
            end
            ST_POP_PC: begin
                stk_re         = 1'b1;
                stk_long       = 1'b1;
                stk_addr       = ssp + UP_OFS;
                redirect_valid = 1'b1;
                redirect_pc    = stk_rdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
    parameter int AW    = 32,
    parameter int S_BIT = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          stk_we,
    input logic          stk_re,
    input logic          stk_long,
    input logic [AW-1:0] stk_addr,
    input logic [AW-1:0] ssp,
    input logic [15:0]   sr,
    input logic          vec_re,
    input logic          redirect_valid
);
    // R8: the PC long write is followed by the SR word write two bytes lower
    assert_pc_then_sr_R8: assert property (@(posedge clk) disable iff (rst)
        (stk_we && stk_long) |=> (stk_we && !stk_long && stk_addr == $past(stk_addr) - AW'(2)));

    // R8: stack pointer drops by the frame size when the SR word is written
    assert_sp_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (stk_we && !stk_long) |=> (ssp == $past(ssp) - AW'(6)));

    // R9: supervisor bit set and vector fetch follows the SR write
    assert_super_set_R9: assert property (@(posedge clk) disable iff (rst)
        (stk_we && !stk_long) |=> (sr[S_BIT] && vec_re && redirect_valid));

    // R10: entry sequence ends after the fetch step
    assert_fetch_ends_R10: assert property (@(posedge clk) disable iff (rst)
        vec_re |=> !busy);

    // R11: SR pop is followed by PC pop two bytes higher
    assert_pop_order_R11: assert property (@(posedge clk) disable iff (rst)
        (stk_re && !stk_long) |=> (stk_re && stk_long && stk_addr == $past(stk_addr) + AW'(2)));

    // R11: stack pointer rises by the frame size after the PC pop
    assert_sp_rise_R11: assert property (@(posedge clk) disable iff (rst)
        (stk_re && stk_long) |=> (ssp == $past(ssp) + AW'(6)));

    // R12: no memory traffic while idle
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!stk_we && !stk_re && !vec_re));

    // R11: never read and write the stack together
    assert_rw_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(stk_we && stk_re));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.AW(AW), .S_BIT(S_BIT)) u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ex_valid = 0;
    logic [AW-1:0] ex_pc = 0;
    logic [AW-1:0] ex_next_pc = 0;
    logic [3:0]    ex_op_hi = 0;
    logic          ex_div_zero = 0;
    logic          ex_trap = 0;
    logic [3:0]    ex_trap_num = 0;
    logic          ex_mem_en = 0;
    logic [1:0]    ex_mem_size = 0;
    logic          ex_mem_addr0 = 0;
    logic          ex_bus_err = 0;
    logic          irq_req = 0;
    logic [7:0]    irq_vec = 0;
    logic          rte_req = 0;
    logic          sr_load = 0;
    logic [15:0]   sr_load_val = 0;
    logic [AW-1:0] stk_rdata;
    logic [AW-1:0] vec_rdata;
    logic          busy;
    logic [7:0]    exc_vector;
    logic [15:0]   sr;
    logic [AW-1:0] ssp;
    logic          stk_we, stk_re, stk_long;
    logic [AW-1:0] stk_addr, stk_wdata;
    logic          vec_re;
    logic [AW-1:0] vec_addr;
    logic          redirect_valid;
    logic [AW-1:0] redirect_pc;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  mem [0:4095];
    logic [11:0] ma;

    always #4 clk = ~clk;

    exc_entry_ctrl u_dut (.*);

    function automatic logic [AW-1:0] handler_of(input logic [AW-1:0] a);
        return 32'h0010_0000 + (a << 4);
    endfunction

    assign vec_rdata = handler_of(vec_addr);
    assign ma        = stk_addr[11:0];
    assign stk_rdata = stk_long ? {mem[ma], mem[ma+1], mem[ma+2], mem[ma+3]}
                                : {16'h0, mem[ma], mem[ma+1]};

    always @(negedge clk) begin
        if (stk_we) begin
            if (stk_long) begin
                mem[ma]   <= stk_wdata[31:24];
                mem[ma+1] <= stk_wdata[23:16];
                mem[ma+2] <= stk_wdata[15:8];
                mem[ma+3] <= stk_wdata[7:0];
            end else begin
                mem[ma]   <= stk_wdata[15:8];
                mem[ma+1] <= stk_wdata[7:0];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected model state
    logic [AW-1:0] m_sp = 32'h800;
    logic [15:0]   m_sr = 16'h2700;
    logic [15:0]   st_sr [0:7];
    logic [AW-1:0] st_pc [0:7];
    int            depth = 0;

    // expected vector / resume choice from requirement priority (R6)
    task automatic model(output bit hit, output logic [7:0] v, output bit nxt, output string tag);
        bit ae;
        ae  = ex_pc[0] || (ex_mem_en && (ex_mem_size == 2'd1 || ex_mem_size == 2'd2) && ex_mem_addr0);
        hit = 1; nxt = 0;
        if (!ex_valid) begin hit = 0; v = 0; tag = "none"; end
        else if (ae)                  begin v = 8'd3;  tag = "R3 addr err"; end
        else if (ex_bus_err)          begin v = 8'd2;  tag = "R5 bus err"; end
        else if (ex_op_hi == 4'hA)    begin v = 8'd10; tag = "R4 line1010"; end
        else if (ex_trap)             begin v = 8'd32 + {4'b0, ex_trap_num}; nxt = 1; tag = "R2 trap"; end
        else if (ex_div_zero)         begin v = 8'd5;  nxt = 1; tag = "R1 div zero"; end
        else if (irq_req)             begin v = irq_vec; nxt = 1; tag = "R5 irq"; end
        else begin hit = 0; v = 0; tag = "none"; end
    endtask

    task automatic clear_ex();
        ex_valid = 0; ex_div_zero = 0; ex_trap = 0; ex_mem_en = 0;
        ex_bus_err = 0; irq_req = 0; ex_mem_addr0 = 0; ex_op_hi = 0;
    endtask

    // caller sets ex_* at a negedge, then calls
    task automatic run_exc(input bit hold);
        bit hit, nxt;
        logic [7:0] v;
        logic [AW-1:0] rp, nsp;
        string tag;
        model(hit, v, nxt, tag);
        rp = nxt ? ex_next_pc : ex_pc;
        @(negedge clk);
        if (!hit) begin
            chk(busy == 1'b0, "R3 no exception expected (busy)", 32'(busy), 0);
            clear_ex();
            return;
        end
        chk(busy == 1'b1, "R10 busy after start", 32'(busy), 1);
        if (!hold) clear_ex();
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy step 2", 32'(busy), 1);
        @(negedge clk);
        chk(redirect_valid && vec_re, "R9 fetch step", 32'(redirect_valid), 1);
        chk(vec_addr == 32'(v) * 4, "R9 vector address", vec_addr, 32'(v) * 4);
        chk(redirect_pc == handler_of(32'(v) * 4), "R9 handler redirect", redirect_pc, handler_of(32'(v) * 4));
        clear_ex();
        @(negedge clk);
        chk(busy == 1'b0, "R10 busy length three", 32'(busy), 0);
        chk(exc_vector == v, tag, 32'(exc_vector), 32'(v));
        nsp = m_sp - 6;
        chk(ssp == nsp, "R8 stack pointer minus 6", ssp, nsp);
        chk({mem[nsp[11:0]], mem[nsp[11:0]+1]} == m_sr, "R8 SR word at top",
            32'({mem[nsp[11:0]], mem[nsp[11:0]+1]}), 32'(m_sr));
        chk({mem[nsp[11:0]+2], mem[nsp[11:0]+3], mem[nsp[11:0]+4], mem[nsp[11:0]+5]} == rp,
            "R7 stacked return PC",
            {mem[nsp[11:0]+2], mem[nsp[11:0]+3], mem[nsp[11:0]+4], mem[nsp[11:0]+5]}, rp);
        chk(sr[13] == 1'b1, "R9 supervisor bit set", 32'(sr), 32'(m_sr | 16'h2000));
        st_sr[depth] = m_sr; st_pc[depth] = rp; depth++;
        m_sp = nsp; m_sr = m_sr | 16'h2000;
    endtask

    task automatic run_rte();
        rte_req = 1;
        @(negedge clk);
        rte_req = 0;
        depth--;
        chk(busy == 1'b1, "R11 busy during return", 32'(busy), 1);
        @(negedge clk);
        chk(sr == st_sr[depth], "R11 SR restored", 32'(sr), 32'(st_sr[depth]));
        chk(redirect_valid && redirect_pc == st_pc[depth], "R11 return PC", redirect_pc, st_pc[depth]);
        @(negedge clk);
        chk(busy == 1'b0 && ssp == m_sp + 6, "R11 stack pointer plus 6", ssp, m_sp + 6);
        m_sp = m_sp + 6; m_sr = st_sr[depth];
    endtask

    task automatic set_ex(input logic [31:0] pc);
        ex_valid = 1; ex_pc = pc; ex_next_pc = pc + 2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk(ssp == 32'h800, "R12 reset SP", ssp, 32'h800);
        chk(sr == 16'h2700, "R12 reset SR", 32'(sr), 32'h2700);
        chk(busy == 0 && !stk_we && !vec_re, "R12 idle after reset", 32'(busy), 0);

        // R1 divide by zero
        set_ex(32'h1000); ex_div_zero = 1; run_exc(0); run_rte();
        // R2 trap 15 and trap 0
        @(negedge clk); set_ex(32'h2000); ex_trap = 1; ex_trap_num = 4'hF; run_exc(0); run_rte();
        @(negedge clk); set_ex(32'h2010); ex_trap = 1; ex_trap_num = 4'h0; run_exc(0); run_rte();
        // R4 reserved line
        @(negedge clk); set_ex(32'h3000); ex_op_hi = 4'hA; run_exc(0); run_rte();
        // R3 odd fetch, odd long access, odd byte access ignored
        @(negedge clk); set_ex(32'h4001); run_exc(0); run_rte();
        @(negedge clk); set_ex(32'h4100); ex_mem_en = 1; ex_mem_size = 2; ex_mem_addr0 = 1; run_exc(0); run_rte();
        @(negedge clk); set_ex(32'h4200); ex_mem_en = 1; ex_mem_size = 0; ex_mem_addr0 = 1; run_exc(0);
        // R6 all causes together: address error wins
        @(negedge clk); set_ex(32'h5000); ex_mem_en = 1; ex_mem_size = 1; ex_mem_addr0 = 1;
        ex_bus_err = 1; ex_op_hi = 4'hA; ex_trap = 1; ex_div_zero = 1; irq_req = 1; irq_vec = 8'd64;
        run_exc(0); run_rte();
        // R5 irq alone, R6 trap over div zero
        @(negedge clk); set_ex(32'h5100); irq_req = 1; irq_vec = 8'd70; run_exc(0); run_rte();
        @(negedge clk); set_ex(32'h5200); ex_trap = 1; ex_trap_num = 4'd3; ex_div_zero = 1; run_exc(0); run_rte();
        // R10 causes held while busy are ignored
        @(negedge clk); set_ex(32'h6000); ex_bus_err = 1; run_exc(1);
        @(negedge clk);
        chk(busy == 0 && ssp == m_sp, "R10 held cause ignored", ssp, m_sp);
        run_rte();
        // R11 user mode returns after nested entries
        @(negedge clk); sr_load = 1; sr_load_val = 16'h0015;
        @(negedge clk); sr_load = 0; m_sr = 16'h0015;
        set_ex(32'h7000); ex_div_zero = 1; run_exc(0);
        @(negedge clk); set_ex(32'h7100); ex_op_hi = 4'hA; run_exc(0);
        run_rte(); run_rte();
        chk(sr == 16'h0015, "R11 user mode back", 32'(sr), 32'h15);

        // random mix
        for (int n = 0; n < 150; n++) begin
            @(negedge clk);
            ex_valid     = ($urandom % 8) != 0;
            ex_pc        = ($urandom & 32'h00FF_FFFE) | 32'(($urandom % 10) == 0);
            ex_next_pc   = ex_pc + 32'(2 * (1 + $urandom % 3));
            ex_op_hi     = (($urandom % 6) == 0) ? 4'hA : 4'($urandom % 10);
            ex_div_zero  = ($urandom % 4) == 0;
            ex_trap      = ($urandom % 4) == 0;
            ex_trap_num  = 4'($urandom);
            ex_mem_en    = ($urandom % 2) == 0;
            ex_mem_size  = 2'($urandom % 3);
            ex_mem_addr0 = ($urandom % 3) == 0;
            ex_bus_err   = ($urandom % 6) == 0;
            irq_req      = ($urandom % 4) == 0;
            irq_vec      = 8'd64 + 8'($urandom % 64);
            begin
                int d0;
                d0 = depth;
                run_exc(($urandom % 4) == 0);
                if (depth != d0) run_rte();
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule